// File: doc/BRIEF.md
# Divide-by-Three System Clock Generator

This block produces the system clock for a processor from one of two source clocks. A select input chooses between an oscillator and an external frequency input. The chosen source is divided by three, which gives a system clock that is high for one source period in every three. A peripheral clock runs at half the system clock rate with an even duty cycle. The oscillator is also passed straight out, unchanged. A sync input holds the divider in a known phase, so several generators that are released from sync together stay in step.

The block also prepares two control inputs for the processor. A raw reset is moved into the system clock domain through a synchroniser chain. It is then stretched so the processor always sees at least the minimum number of reset clocks. Two ready sources, each gated by its own active-low enable, are ORed together. The result is registered on a rising system clock edge and presented on the following falling edge.

Top module: `clkgen_top`

## Requirements
- R1: `src_sel` = 0 clocks the divider from `osc_clk`; `src_sel` = 1 clocks it from `ext_clk`.
- R2: While `sync_in` is low, `sys_clk` repeats with a period of exactly three source clock periods.
- R3: In each three-period cycle, `sys_clk` is high for exactly one source period.
- R4: While `sync_in` is high, `sys_clk` stays low. After `sync_in` falls, the first source rising edge leaves `sys_clk` low and the second one drives it high.
- R5: `osc_out` follows `osc_clk` unchanged, whatever the state of `src_sel`.
- R6: A raw reset seen at one rising edge of `sys_clk` drives `rst_out` high at the third rising edge of `sys_clk` (two synchroniser stages plus the output register).
- R7: `rst_out` is high for N+3 system clock cycles when `rst_raw` is high for N ≥ 1 rising edges, so it is never shorter than four cycles. It is low when `rst_raw` has been low for long enough.
- R8: `periph_clk` toggles on every rising edge of `sys_clk`, giving a half-rate clock that is high for three source periods and low for three.
- R9: `rdy_out` is the OR of (`rdy_a` AND NOT `rdy_a_en_n`) and (`rdy_b` AND NOT `rdy_b_en_n`). It is captured on a rising edge of `sys_clk` and appears on the next falling edge.
- R10: A ready input whose enable is high (disabled) has no effect on `rdy_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator source clock |
| ext_clk | input | 1 | External frequency source clock |
| src_sel | input | 1 | Source select: 0 oscillator, 1 external |
| sync_in | input | 1 | Divider alignment; holds the phase at zero while high |
| rst_raw | input | 1 | Asynchronous raw reset request |
| rdy_a | input | 1 | Ready source A |
| rdy_a_en_n | input | 1 | Active-low enable for ready source A |
| rdy_b | input | 1 | Ready source B |
| rdy_b_en_n | input | 1 | Active-low enable for ready source B |
| sys_clk | output | 1 | Divided system clock, one-third duty |
| periph_clk | output | 1 | Half-rate peripheral clock |
| osc_out | output | 1 | Oscillator passed through |
| rst_out | output | 1 | Synchronised, stretched reset |
| rdy_out | output | 1 | Synchronised ready |

## Verification
The bench releases sync and checks the exact phase of the first high pulse on both sources. A divider that kept counting during sync, or that started in the wrong phase, would put the pulse in the wrong sample slot, and a wrong count limit would break the period-three pattern. The reset pulse-width tests use a single-edge raw pulse and a ten-edge raw pulse. These catch a missing stretch (a one-cycle `rst_out`), a wrong synchroniser depth (shifted onset) and an off-by-one hold counter (three or five cycles). The ready tests cover each input with its enable on and off. An inverted enable, or an AND where the OR should be, shows up as a wrong `rdy_out` level at the falling edge.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
   typedef enum logic {
      SRC_OSC = 1'b0,
      SRC_EXT = 1'b1
   } clk_src_e;
endpackage

// File: rtl/clkgen_src_mux.sv
module clkgen_src_mux
   import clkgen_pkg::*;
(
   input  logic osc_clk,
   input  logic ext_clk,
   input  logic src_sel,
   output logic src_clk
);
   always_comb begin
      unique case (clk_src_e'(src_sel))
         SRC_EXT: src_clk = ext_clk;
         default: src_clk = osc_clk;
      endcase
   end
endmodule

// File: rtl/clkgen_divider.sv
module clkgen_divider #(
   parameter int DIV  = 3,
   parameter int HIGH = 1
) (
   input  logic src_clk,
   input  logic sync_in,
   output logic sys_clk
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST_C = CW'(DIV - 1);
   localparam logic [CW-1:0] RISE_C = CW'(DIV - HIGH);

   if (DIV < 2) begin : g_bad_div
      $error("clkgen_divider: DIV must be at least 2");
   end
   if (HIGH < 1 || HIGH >= DIV) begin : g_bad_high
      $error("clkgen_divider: HIGH must lie in 1..DIV-1");
   end

   logic [CW-1:0] cnt_q, cnt_d;
   logic          sys_q;

   always_comb begin
      if (sync_in)              cnt_d = '0;
      else if (cnt_q == LAST_C) cnt_d = '0;
      else                      cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge src_clk) begin
      cnt_q <= cnt_d;
      sys_q <= (cnt_d >= RISE_C);
   end

   assign sys_clk = sys_q;

   // R4: sync holds the phase at zero with the clock low
   assert_sync_hold_R4: assert property (@(posedge src_clk)
      sync_in |=> (cnt_q == '0) && !sys_q);
   // R2: the phase wraps after its last step
   assert_phase_wrap_R2: assert property (@(posedge src_clk) disable iff (sync_in)
      (cnt_q == LAST_C) |=> (cnt_q == '0));
   // R3: the high pulse ends exactly when the phase returns to zero
   assert_fall_at_zero_R3: assert property (@(posedge src_clk) disable iff (sync_in)
      $fell(sys_q) |-> (cnt_q == '0));
endmodule

// File: rtl/clkgen_rst_sync.sv
module clkgen_rst_sync #(
   parameter int STAGES   = 2,
   parameter int MIN_HOLD = 4
) (
   input  logic clk,
   input  logic rst_raw,
   output logic rst_out
);
   localparam int HW = $clog2(MIN_HOLD);

   if (STAGES < 2) begin : g_bad_stages
      $error("clkgen_rst_sync: STAGES must be at least 2");
   end
   if (MIN_HOLD < 2) begin : g_bad_hold
      $error("clkgen_rst_sync: MIN_HOLD must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic [HW-1:0]     left_q;
   logic              out_q;
   logic              seen;

   always_ff @(posedge clk) sh_q <= {sh_q[STAGES-2:0], rst_raw};

   assign seen = sh_q[STAGES-1];

   always_ff @(posedge clk) begin
      if (seen) begin
         out_q  <= 1'b1;
         left_q <= HW'(MIN_HOLD - 1);
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end else begin
         out_q <= 1'b0;
      end
   end

   assign rst_out = out_q;

   // Checker state: consecutive high cycles of the output, saturating
   logic [HW:0] run_q;
   logic        armed_q = 1'b0;
   always_ff @(posedge clk) begin
      armed_q <= 1'b1;
      if (!out_q)                          run_q <= '0;
      else if (run_q < (HW+1)'(MIN_HOLD))  run_q <= run_q + 1'b1;
   end

   // R7: every reset pulse lasts at least MIN_HOLD clocks
   assert_rst_min_width_R7: assert property (@(posedge clk) disable iff (!armed_q)
      $fell(out_q) |-> (run_q >= (HW+1)'(MIN_HOLD)));
endmodule

// File: rtl/clkgen_rdy_sync.sv
module clkgen_rdy_sync #(
   parameter bit OUT_ON_FALL = 1'b1
) (
   input  logic clk,
   input  logic rdy_a,
   input  logic rdy_a_en_n,
   input  logic rdy_b,
   input  logic rdy_b_en_n,
   output logic rdy_out
);
   logic req;
   logic cap_q;
   logic out_q;

   assign req = (rdy_a & ~rdy_a_en_n) | (rdy_b & ~rdy_b_en_n);

   always_ff @(posedge clk) cap_q <= req;

   if (OUT_ON_FALL) begin : g_fall
      always_ff @(negedge clk) out_q <= cap_q;
   end else begin : g_rise
      always_ff @(posedge clk) out_q <= cap_q;
   end

   assign rdy_out = out_q;

   // R10: with both sources disabled the captured request is low
   assert_disabled_ignored_R10: assert property (@(posedge clk)
      (rdy_a_en_n && rdy_b_en_n) |=> !cap_q);
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top #(
   parameter int DIV        = 3,
   parameter int HIGH       = 1,
   parameter int RST_STAGES = 2,
   parameter int RST_HOLD   = 4,
   parameter bit RDY_FALL   = 1'b1
) (
   input  logic osc_clk,
   input  logic ext_clk,
   input  logic src_sel,
   input  logic sync_in,
   input  logic rst_raw,
   input  logic rdy_a,
   input  logic rdy_a_en_n,
   input  logic rdy_b,
   input  logic rdy_b_en_n,
   output logic sys_clk,
   output logic periph_clk,
   output logic osc_out,
   output logic rst_out,
   output logic rdy_out
);
   logic src_clk;
   logic periph_q;

   clkgen_src_mux u_mux (
      .osc_clk (osc_clk),
      .ext_clk (ext_clk),
      .src_sel (src_sel),
      .src_clk (src_clk)
   );

   clkgen_divider #(.DIV(DIV), .HIGH(HIGH)) u_div (
      .src_clk (src_clk),
      .sync_in (sync_in),
      .sys_clk (sys_clk)
   );

   always_ff @(posedge sys_clk or posedge sync_in) begin
      if (sync_in) periph_q <= 1'b0;
      else         periph_q <= ~periph_q;
   end

   assign periph_clk = periph_q;
   assign osc_out    = osc_clk;

   clkgen_rst_sync #(.STAGES(RST_STAGES), .MIN_HOLD(RST_HOLD)) u_rst (
      .clk     (sys_clk),
      .rst_raw (rst_raw),
      .rst_out (rst_out)
   );

   clkgen_rdy_sync #(.OUT_ON_FALL(RDY_FALL)) u_rdy (
      .clk        (sys_clk),
      .rdy_a      (rdy_a),
      .rdy_a_en_n (rdy_a_en_n),
      .rdy_b      (rdy_b),
      .rdy_b_en_n (rdy_b_en_n),
      .rdy_out    (rdy_out)
   );

   // R8: the peripheral clock alternates on successive system edges
   assert_periph_toggle_R8: assert property (@(posedge sys_clk) disable iff (sync_in)
      ##1 (periph_q != $past(periph_q)));
endmodule

// File: tb/clkgen_top_tb_top.sv
module clkgen_top_tb_top;
   logic osc_clk = 1'b0;
   logic ext_clk = 1'b0;
   logic src_sel = 1'b0;
   logic sync_in = 1'b1;
   logic rst_raw = 1'b1;
   logic rdy_a = 1'b0, rdy_a_en_n = 1'b1, rdy_b = 1'b0, rdy_b_en_n = 1'b1;
   logic sys_clk, periph_clk, osc_out, rst_out, rdy_out;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 osc_clk = ~osc_clk;
   always #7 ext_clk = ~ext_clk;

   clkgen_top dut_i (
      .osc_clk(osc_clk), .ext_clk(ext_clk), .src_sel(src_sel), .sync_in(sync_in),
      .rst_raw(rst_raw), .rdy_a(rdy_a), .rdy_a_en_n(rdy_a_en_n), .rdy_b(rdy_b),
      .rdy_b_en_n(rdy_b_en_n), .sys_clk(sys_clk), .periph_clk(periph_clk),
      .osc_out(osc_out), .rst_out(rst_out), .rdy_out(rdy_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic src_neg(input bit use_ext);
      if (use_ext) @(negedge ext_clk); else @(negedge osc_clk);
      #1;
   endtask

   task automatic sys_neg();
      @(negedge sys_clk);
      #1;
   endtask

   // R1 R2 R3 R4 R8: divider pattern from one source
   task automatic t_divide(input bit use_ext, input string rsel);
      logic s[30];
      logic p[30];
      int bad_hold = 0, bad_pat = 0, ones = 0, bad_per = 0;
      src_neg(use_ext);
      sync_in = 1'b1;
      src_sel = use_ext;
      for (int i = 0; i < 4; i++) begin
         src_neg(use_ext);
         if (sys_clk !== 1'b0) bad_hold++;
      end
      check(bad_hold == 0, "R4 sync holds low", bad_hold, 0);
      sync_in = 1'b0;
      for (int i = 0; i < 30; i++) begin
         src_neg(use_ext);
         s[i] = sys_clk;
         p[i] = periph_clk;
      end
      for (int i = 0; i < 30; i++) begin
         if (s[i] !== ((i % 3) == 1)) bad_pat++;
         if (s[i] === 1'b1) ones++;
      end
      check(s[0] === 1'b0 && s[1] === 1'b1, "R4 first pulse phase", int'(s[1]), 1);
      check(bad_pat == 0, {rsel, " R2 period three"}, bad_pat, 0);
      check(ones == 10, "R3 one high slot of three", ones, 10);
      for (int i = 0; i < 24; i++) begin
         if (p[i] === p[i+3] || p[i] !== p[i+6]) bad_per++;
      end
      check(bad_per == 0, "R8 periph half rate", bad_per, 0);
   endtask

   // R5: oscillator passthrough
   task automatic t_osc_pass();
      int bad = 0;
      for (int i = 0; i < 4; i++) begin
         @(posedge osc_clk); #1;
         if (osc_out !== 1'b1) bad++;
         @(negedge osc_clk); #1;
         if (osc_out !== 1'b0) bad++;
      end
      check(bad == 0, "R5 osc passthrough", bad, 0);
   endtask

   // R6 R7: reset pulse of n rising edges
   task automatic t_reset(input int n);
      int bad = 0, highs = 0;
      logic h[24];
      sys_neg();
      rst_raw = 1'b1;
      for (int k = 1; k < 24; k++) begin
         sys_neg();
         if (k == n) rst_raw = 1'b0;
         h[k] = rst_out;
      end
      for (int k = 1; k < 24; k++) begin
         if (h[k] !== (k >= 3 && k <= n + 5)) bad++;
         if (h[k] === 1'b1) highs++;
      end
      check(h[2] === 1'b0 && h[3] === 1'b1, "R6 onset at third edge", int'(h[3]), 1);
      check(highs == n + 3, "R7 stretched width", highs, n + 3);
      check(bad == 0, "R7 pulse shape", bad, 0);
   endtask

   // R9 R10: ready combination case
   task automatic t_ready(input logic a, input logic an, input logic b, input logic bn,
                          input string req);
      logic exp;
      sys_neg();
      rdy_a = a; rdy_a_en_n = an; rdy_b = b; rdy_b_en_n = bn;
      exp = (a & ~an) | (b & ~bn);
      sys_neg();
      check(rdy_out === exp, req, int'(rdy_out), int'(exp));
   endtask

   task automatic t_ready_latency();
      t_ready(1'b0, 1'b1, 1'b0, 1'b1, "R10 idle low");
      @(posedge sys_clk); #1;
      rdy_a = 1'b1; rdy_a_en_n = 1'b0;
      @(posedge sys_clk); #1;
      check(rdy_out === 1'b0, "R9 not before falling edge", int'(rdy_out), 0);
      sys_neg();
      check(rdy_out === 1'b1, "R9 on falling edge", int'(rdy_out), 1);
   endtask

   initial begin
      repeat (200000) @(posedge osc_clk);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (6) @(negedge osc_clk);
      check(sys_clk === 1'b0, "R4 reset state clock", int'(sys_clk), 0);
      #1 sync_in = 1'b0;
      repeat (8) sys_neg();
      rst_raw = 1'b0;
      repeat (10) sys_neg();
      check(rst_out === 1'b0, "R7 reset released", int'(rst_out), 0);
      check(rdy_out === 1'b0, "R10 ready idle", int'(rdy_out), 0);

      t_divide(1'b0, "R1 osc");
      t_osc_pass();
      t_divide(1'b1, "R1 ext");
      t_osc_pass();
      t_divide(1'b0, "R1 back to osc");

      t_reset(1);
      t_reset(10);

      t_ready_latency();
      t_ready(1'b1, 1'b1, 1'b0, 1'b1, "R10 A disabled");
      t_ready(1'b0, 1'b1, 1'b1, 1'b0, "R9 B enabled");
      t_ready(1'b0, 1'b1, 1'b1, 1'b1, "R10 B disabled");
      t_ready(1'b1, 1'b0, 1'b1, 1'b0, "R9 both enabled");
      t_ready(1'b1, 1'b1, 1'b1, 1'b1, "R10 both disabled");
      t_ready(1'b0, 1'b0, 1'b0, 1'b0, "R9 enabled but low");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule